// File: doc/BRIEF.md
# MDIO Management Frame Master

This block carries out one management transaction at a time on a two-wire serial management bus. The host gives a read/write flag, a 5-bit PHY address, a 5-bit register address and, for a write, a 16-bit data word, and raises `start` for one clock. The block then divides the system clock to produce the management clock `mdc` and shifts the frame out on the data line. The data line is split into a driven value `mdio_o`, an enable `mdio_oe` and a sampled input `mdio_i`, so a pad or a bench can put the three together into one open line.

Every frame opens with an extended run of 40 one bits instead of the usual 32. On a read the block releases the line after the register address. It waits out the two turnaround periods and then shifts in sixteen bits from the PHY. On a write it drives the turnaround pair itself and then the data word. In both cases the line goes back to high impedance once the frame ends. `busy` covers the whole frame. A one-clock `done` pulse marks its end, and read data is presented at that moment and then held.

The controller has eight states. `ST_IDLE` goes to `ST_PRE` on an accepted start. `ST_PRE` goes to `ST_SOF` after the preamble bits. `ST_SOF` goes to `ST_OPC` after two bits, `ST_OPC` to `ST_PHYAD` after two bits, `ST_PHYAD` to `ST_REGAD` after five bits and `ST_REGAD` to `ST_TURN` after five bits. `ST_TURN` goes to `ST_DATA` after two bits, and `ST_DATA` returns to `ST_IDLE` after sixteen bits, raising `done`. Each step happens at the end of a bit period.

Top module: `mdio_frame_master`

## Requirements
- R1: Frame bits are numbered 0 to 71 in the order of the `mdc` rising edges. Bits 0..39 are driven ones (`mdio_oe`=1, `mdio_o`=1).
- R2: Bits 40,41 are driven 0 then 1. Bits 42,43 are driven 1,0 when `rd_req`=1 and 0,1 when `rd_req`=0.
- R3: Bits 44..48 carry `phy_addr` from bit 4 down to bit 0, and bits 49..53 carry `reg_addr` from bit 4 down to bit 0. All of them are driven.
- R4: In a write, bits 54,55 are driven 1 then 0, and bits 56..71 carry `wr_data` from bit 15 down to bit 0. All of them are driven.
- R5: In a read, `mdio_oe` is 0 for bits 54..71. Bits 54,55 of `mdio_i` are ignored. The `mdio_i` value at the `mdc` rising edge of bit 56+k becomes `rd_data[15-k]`.
- R6: `mdc` has a period of `DIV` clocks, with `DIV`/2 clocks low followed by `DIV`/2 clocks high. `mdio_o` changes only at the clock edge where `mdc` goes low, and `mdc` is 0 while idle.
- R7: A start sampled while idle raises `busy` on the next clock. `busy` then stays high for exactly 72×`DIV` clocks.
- R8: `done` is high for exactly one clock, the first clock after `busy` falls. `rd_data` changes only together with `done`, only after a read, and holds its value otherwise.
- R9: A `start` while `busy` is high is ignored. The running frame, its fields and its length are unchanged, and no second frame follows.
- R10: `mdio_oe` is 0 whenever `busy` is 0, including right after a write frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one transaction, sampled while idle |
| rd_req | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 5 | Register address |
| wr_data | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock end-of-frame pulse |
| rd_data | output | 16 | Last read word, held |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line sampled value |

## Verification
A start presented at one falling clock edge is taken at the next rising edge. `busy` must then read high on exactly 72×`DIV` consecutive falling edges. `done` and the new `rd_data` appear on the falling edge right after that, and `done` is gone one clock later. The bench counts falling edges from the start and checks each of these results on exactly that edge. Frame bits are read at each `mdc` rising edge, half a bit period after they change. The bench PHY model drives `mdio_i` one nanosecond after each rising edge, so every value is settled long before the edge that samples it. The sweep covers every PHY address with both reads and writes. It also injects starts in mid-frame and drives junk during turnaround.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SOF,
        ST_OPC,
        ST_PHYAD,
        ST_REGAD,
        ST_TURN,
        ST_DATA
    } mdio_state_e;

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic period_end,
    output logic rise_stb,
    output logic mdc
);
    localparam int HALF  = DIV / 2;
    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DIV - 1);
    localparam logic [CNT_W-1:0] RISE_CNT = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt;

    assign period_end = run && (cnt == LAST_CNT);
    assign rise_stb   = run && (cnt == RISE_CNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (load) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (run) begin
            cnt <= (cnt == LAST_CNT) ? '0 : cnt + 1'b1;
            if (cnt == RISE_CNT)
                mdc <= 1'b1;
            else if (cnt == LAST_CNT)
                mdc <= 1'b0;
        end
    end

endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic             din,
    output logic [WIDTH-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            word <= '0;
        else if (sample_en)
            word <= {word[WIDTH-2:0], din};
    end

endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
    import mdio_master_pkg::*;
#(
    parameter int PRE_BITS = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              period_end,
    input  logic              rise_stb,
    input  logic [DATA_W-1:0] rx_word,
    output logic              load,
    output logic              busy,
    output logic              sample_en,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int LONGEST = (PRE_BITS > DATA_W) ? PRE_BITS : DATA_W;
    localparam int BC_W    = $clog2(LONGEST);
    localparam int AIX_W   = $clog2(ADDR_W);
    localparam int DIX_W   = $clog2(DATA_W);
    localparam logic [AIX_W-1:0] A_TOP = AIX_W'(ADDR_W - 1);
    localparam logic [DIX_W-1:0] D_TOP = DIX_W'(DATA_W - 1);

    mdio_state_e       state, state_n;
    logic [BC_W-1:0]   bc, bc_n;
    logic              rd_q;
    logic [ADDR_W-1:0] phy_q, reg_q;
    logic [DATA_W-1:0] wd_q;
    logic [BC_W-1:0]   last_bc;
    logic              frame_end;

    // index of the final bit in each field
    always_comb begin
        unique case (state)
            ST_PRE:              last_bc = BC_W'(PRE_BITS - 1);
            ST_PHYAD, ST_REGAD:  last_bc = BC_W'(ADDR_W - 1);
            ST_DATA:             last_bc = BC_W'(DATA_W - 1);
            default:             last_bc = BC_W'(1);
        endcase
    end

    assign load      = (state == ST_IDLE) && start;
    assign busy      = (state != ST_IDLE);
    assign frame_end = (state == ST_DATA) && period_end && (bc == last_bc);
    assign sample_en = (state == ST_DATA) && rd_q && rise_stb;

    // next-state logic
    always_comb begin
        state_n = state;
        bc_n    = bc;
        if (load) begin
            state_n = ST_PRE;
            bc_n    = '0;
        end else if (busy && period_end) begin
            if (bc == last_bc) begin
                bc_n = '0;
                unique case (state)
                    ST_PRE:   state_n = ST_SOF;
                    ST_SOF:   state_n = ST_OPC;
                    ST_OPC:   state_n = ST_PHYAD;
                    ST_PHYAD: state_n = ST_REGAD;
                    ST_REGAD: state_n = ST_TURN;
                    ST_TURN:  state_n = ST_DATA;
                    ST_DATA:  state_n = ST_IDLE;
                    ST_IDLE:  state_n = ST_IDLE;
                endcase
            end else begin
                bc_n = bc + 1'b1;
            end
        end
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bc      <= '0;
            rd_q    <= 1'b0;
            phy_q   <= '0;
            reg_q   <= '0;
            wd_q    <= '0;
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            state <= state_n;
            bc    <= bc_n;
            done  <= frame_end;
            if (load) begin
                rd_q  <= rd_req;
                phy_q <= phy_addr;
                reg_q <= reg_addr;
                wd_q  <= wr_data;
            end
            if (frame_end && rd_q)
                rd_data <= rx_word;
        end
    end

    // line outputs for the bit in flight
    always_comb begin
        mdio_o  = 1'b0;
        mdio_oe = 1'b1;
        unique case (state)
            ST_IDLE: mdio_oe = 1'b0;
            ST_PRE:  mdio_o  = 1'b1;
            ST_SOF:  mdio_o  = (bc == BC_W'(1));
            ST_OPC:  mdio_o  = rd_q ? (bc == '0) : (bc == BC_W'(1));
            ST_PHYAD: mdio_o = phy_q[A_TOP - bc[AIX_W-1:0]];
            ST_REGAD: mdio_o = reg_q[A_TOP - bc[AIX_W-1:0]];
            ST_TURN: begin
                mdio_oe = !rd_q;
                mdio_o  = !rd_q && (bc == '0);
            end
            ST_DATA: begin
                mdio_oe = !rd_q;
                mdio_o  = !rd_q && wd_q[D_TOP - bc[DIX_W-1:0]];
            end
        endcase
    end

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master #(
    parameter int DIV      = 4,
    parameter int PRE_BITS = 40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        rd_req,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wr_data,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    import mdio_master_pkg::*;

    logic              load;
    logic              period_end;
    logic              rise_stb;
    logic              sample_en;
    logic [DATA_W-1:0] rx_word;

    mdio_clkdiv #(.DIV(DIV)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .run        (busy),
        .period_end (period_end),
        .rise_stb   (rise_stb),
        .mdc        (mdc)
    );

    mdio_rx_shift #(.WIDTH(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .din       (mdio_i),
        .word      (rx_word)
    );

    mdio_ctrl #(.PRE_BITS(PRE_BITS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .rd_req     (rd_req),
        .phy_addr   (phy_addr),
        .reg_addr   (reg_addr),
        .wr_data    (wr_data),
        .period_end (period_end),
        .rise_stb   (rise_stb),
        .rx_word    (rx_word),
        .load       (load),
        .busy       (busy),
        .sample_en  (sample_en),
        .done       (done),
        .rd_data    (rd_data),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe)
    );

endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk #(
    parameter int DIV = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [15:0] rd_data,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    localparam int HALF = DIV / 2;

    int hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_cnt <= 0;
        else if (mdc)
            hi_cnt <= hi_cnt + 1;
        else
            hi_cnt <= 0;
    end

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R7

    AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_RDDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> done); // R8

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc)); // R10

    AST_DATA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$stable(mdio_o)) |-> !mdc); // R6

    AST_MDC_HIGH_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc) |-> (hi_cnt == HALF)); // R6

endmodule

bind mdio_frame_master mdio_frame_master_chk #(.DIV(DIV)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .rd_data (rd_data),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/mdio_frame_master_test.sv
`timescale 1ns/1ps
module mdio_frame_master_test;
    localparam int DIV   = 4;
    localparam int PRE   = 40;
    localparam int FRAME = PRE + 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_req = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_i = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    mdio_frame_master #(.DIV(DIV), .PRE_BITS(PRE)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // expected {oe, o} of frame bit idx
    function automatic logic [1:0] exp_bit(input int idx, input bit rd,
            input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd);
        if (idx < PRE)       return 2'b11;
        if (idx == PRE)      return 2'b10;
        if (idx == PRE + 1)  return 2'b11;
        if (idx == PRE + 2)  return {1'b1, rd};
        if (idx == PRE + 3)  return {1'b1, !rd};
        if (idx < PRE + 9)   return {1'b1, pa[PRE + 8 - idx]};
        if (idx < PRE + 14)  return {1'b1, ra[PRE + 13 - idx]};
        if (rd)              return 2'b00;
        if (idx == PRE + 14) return 2'b11;
        if (idx == PRE + 15) return 2'b10;
        return {1'b1, wd[FRAME - 1 - idx]};
    endfunction

    task automatic run_txn(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input logic [15:0] phy_word,
                           input bit inject);
        logic [FRAME-1:0] seen_o, seen_oe;
        int cycles;
        int bad_pre, bad_hdr, bad_addr, bad_tail;
        realtime t0, t1;
        logic [15:0] prev = rd_data;
        @(negedge clk);
        start = 1'b1; rd_req = rd; phy_addr = pa; reg_addr = ra; wr_data = wd;
        @(negedge clk);
        start = 1'b0;
        cycles = 0; t0 = 0; t1 = 0;
        fork
            begin
                for (int k = 0; k < FRAME; k++) begin
                    @(posedge mdc);
                    if (k == 0) t0 = $realtime;
                    if (k == 1) t1 = $realtime;
                    seen_o[k]  = mdio_o;
                    seen_oe[k] = mdio_oe;
                    #1;
                    if (k + 1 >= PRE + 16)
                        mdio_i = phy_word[FRAME - 2 - k];
                    else if (k + 1 >= PRE + 14)
                        mdio_i = ~phy_word[15];   // junk in turnaround
                    else
                        mdio_i = k[0];
                end
            end
            begin
                while (busy === 1'b1) begin
                    cycles++;
                    if (inject && cycles == 100) begin
                        start = 1'b1; rd_req = !rd; phy_addr = ~pa;
                        reg_addr = ~ra; wr_data = ~wd;
                    end else begin
                        start = 1'b0;
                    end
                    @(negedge clk);
                end
            end
        join
        start = 1'b0;
        bad_pre = 0; bad_hdr = 0; bad_addr = 0; bad_tail = 0;
        for (int k = 0; k < FRAME; k++) begin
            logic [1:0] e;
            bit bad;
            e = exp_bit(k, rd, pa, ra, wd);
            bad = (seen_oe[k] !== e[1]) || (e[1] && seen_o[k] !== e[0]);
            if (bad) begin
                if (k < PRE)           bad_pre++;
                else if (k < PRE + 4)  bad_hdr++;
                else if (k < PRE + 14) bad_addr++;
                else                   bad_tail++;
            end
        end
        check(bad_pre == 0, "R1", "preamble bit errors", bad_pre, 0);
        check(bad_hdr == 0, "R2", "start/opcode bit errors", bad_hdr, 0);
        check(bad_addr == 0, "R3", "address bit errors", bad_addr, 0);
        if (rd) check(bad_tail == 0, "R5", "read turnaround/data release errors", bad_tail, 0);
        else    check(bad_tail == 0, "R4", "write turnaround/data errors", bad_tail, 0);
        check((t1 - t0) == DIV * 5.0, "R6", "mdc period ps",
              longint'((t1 - t0) * 1000), longint'(DIV * 5000));
        check(cycles == FRAME * DIV, inject ? "R9" : "R7", "busy cycles", cycles, FRAME * DIV);
        check(done === 1'b1, "R8", "done after busy", done, 1);
        check(rd_data === (rd ? phy_word : prev), rd ? "R5" : "R8", "rd_data",
              rd_data, rd ? phy_word : prev);
        check(mdio_oe === 1'b0 && mdc === 1'b0, "R10", "line released/mdc low at end",
              {mdio_oe, mdc}, 0);
        @(negedge clk);
        check(done === 1'b0, "R8", "done width", done, 0);
        check(busy === 1'b0, "R9", "no frame after ignored start", busy, 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check({busy, done, mdc, mdio_oe} === 4'b0 && rd_data === 16'h0, "R10",
              "reset state", {busy, done, mdc, mdio_oe, rd_data}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({busy, mdc, mdio_oe} === 3'b0, "R6", "idle after reset", {busy, mdc, mdio_oe}, 0);
        for (int i = 0; i < 32; i++) begin
            run_txn(1'b0, 5'(i), 5'(31 - i), 16'(i * 16'h0841) ^ 16'hA5C3, 16'h0, (i % 8) == 3);
            run_txn(1'b1, 5'(i), 5'(i) ^ 5'h15, 16'(i * 16'h1357) ^ 16'h8001,
                    16'(i * 16'h2B65) ^ 16'h4C1E, (i % 8) == 5);
        end
        for (int b = 0; b < 16; b++)
            run_txn(1'b1, 5'h1F, 5'h00, 16'h0, 16'h1 << b, 1'b0);
        run_txn(1'b1, 5'h00, 5'h1F, 16'h0, 16'hFFFF, 1'b0);
        run_txn(1'b0, 5'h1F, 5'h1F, 16'hFFFF, 16'h0, 1'b0);
        run_txn(1'b1, 5'h0A, 5'h05, 16'h0, 16'h0000, 1'b1);
        run_txn(1'b0, 5'h00, 5'h00, 16'h0000, 16'h0, 1'b0);
        finish_run();
    end

endmodule